// File: doc/BRIEF.md
# Common Interrupt Distribution Unit

This unit takes a set of shared, level-sensitive interrupt lines from outside the core cluster and decides which of up to four cores sees each one. Every common interrupt has its own small configuration: a core mask naming the eligible cores, a distribution scheme and a mask bit. It drives one request line per core for each common interrupt. A single global enable gates all delivery.

Configuration arrives on a one-cycle command port. Each command carries an opcode, an interrupt index and a data word. There are three distribution schemes. Fixed delivery sends the interrupt to one core only. Broadcast delivery sends it to every core in the mask. Load-balanced delivery hands the interrupt to one core at a time. Each core returns a completion pulse, and the unit uses it to pass the next assertion on to the next eligible core in rotation.

Top module: `cidu_top`

## Requirements
- R1: After reset every interrupt is masked, every core mask is zero, the unit is disabled, the scheme is load-balanced, and all request outputs are low.
- R2: Commands use opcode 0 for the core mask, 1 for the mode word, 2 for the mask bit and 3 for the global enable. Until an enable command (opcode 3, any index and any data) has been accepted, no request output is asserted.
- R3: A mask command with data bit 0 set masks the addressed interrupt, so none of its outputs assert. Data bit 0 clear unmasks it.
- R4: Mode field value 1 (data bits [1:0]) selects fixed delivery. While the input is high, only the lowest set bit of the core mask is driven.
- R5: Mode field value 3 behaves exactly like value 1. The other bits of the mode word, including the trigger-type bit 4, do not change the routing.
- R6: Mode field value 2 drives every core whose bit is set in the core mask.
- R7: Mode field value 0 selects load-balanced delivery. At most one core inside the mask is driven, and the same core stays selected until it pulses its completion input. Completion pulses from other cores have no effect.
- R8: In load-balanced delivery, the first core chosen after reset is the lowest set mask bit. After a completion from the owning core, the next core is the next set mask bit above it, wrapping from the top core back to core 0.
- R9: An interrupt whose core mask is zero asserts no output.
- R10: Outputs are registered. A change on an interrupt input, on a completion input, or in the configuration shows on the outputs after the next rising clock edge. Output bit i*N_CORE+c is interrupt i for core c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | Opcode: 0 core mask, 1 mode, 2 mask bit, 3 enable |
| cmd_idx | input | IDX_W | Addressed common interrupt |
| cmd_data | input | DATA_W | Command data word |
| irq_in | input | N_IRQ | Level-sensitive common interrupt inputs |
| core_done | input | N_CORE | Per-core completion pulses |
| irq_out | output | N_IRQ*N_CORE | Request lines, bit i*N_CORE+c is interrupt i to core c |

## Verification
The hardest case to reach from the ports is the load-balanced rotation. The owner changes only on a completion from the owning core, so the history of completions decides which core is served next. The stimulus keeps one interrupt high and sends completion pulses in a chosen order: first a pulse from a core that does not own the interrupt, then pulses from the successive owners. This steps the owner through every set bit of a sparse mask that skips one core, including the wrap from the top core back to core 0. Mixed patterns then drive all four interrupts at once, each in a different scheme.

// File: rtl/cidu_pkg.sv
package cidu_pkg;

  typedef enum logic [1:0] {
    OP_DEST   = 2'd0,
    OP_MODE   = 2'd1,
    OP_MASK   = 2'd2,
    OP_ENABLE = 2'd3
  } cidu_op_e;

  typedef enum logic [1:0] {
    DIST_RR      = 2'd0,
    DIST_ONE     = 2'd1,
    DIST_ALL     = 2'd2,
    DIST_ONE_ALT = 2'd3
  } cidu_dist_e;

endpackage

// File: rtl/cidu_cmd_dec.sv
module cidu_cmd_dec
  import cidu_pkg::*;
#(
  parameter int N_IRQ = 4,
  localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [IDX_W-1:0] cmd_idx,
  output logic [N_IRQ-1:0] wr_dest,
  output logic [N_IRQ-1:0] wr_mode,
  output logic [N_IRQ-1:0] wr_mask,
  output logic             en_q
);

  cidu_op_e op;
  assign op = cidu_op_e'(cmd_op);

  always_comb begin
    wr_dest = '0;
    wr_mode = '0;
    wr_mask = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (cmd_valid && int'(cmd_idx) == i) begin
        wr_dest[i] = (op == OP_DEST);
        wr_mode[i] = (op == OP_MODE);
        wr_mask[i] = (op == OP_MASK);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= 1'b0;
    end else if (cmd_valid && op == OP_ENABLE) begin
      en_q <= 1'b1;
    end
  end

  // R2: the enable flag can only be raised by an enable command
  p_enable_source_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q) |-> ($past(cmd_valid) && $past(cmd_op) == 2'd3));

endmodule

// File: rtl/cidu_route.sv
module cidu_route
  import cidu_pkg::*;
#(
  parameter int N_CORE = 4,
  parameter int DATA_W = 8,
  localparam int CORE_W = (N_CORE > 1) ? $clog2(N_CORE) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              irq_in,
  input  logic [N_CORE-1:0] done,
  input  logic              wr_dest,
  input  logic              wr_mode,
  input  logic              wr_mask,
  input  logic [DATA_W-1:0] data,
  output logic [N_CORE-1:0] out_q
);

  logic [N_CORE-1:0] dest_q;
  cidu_dist_e        dist_q;
  logic              mask_q;
  logic [CORE_W-1:0] own_q;
  logic              own_v_q;
  logic [CORE_W-1:0] last_q;

  logic              active;
  logic              rel;
  logic              keep;
  logic [CORE_W-1:0] base;
  logic [CORE_W-1:0] nxt;
  logic [CORE_W-1:0] sel;
  logic [N_CORE-1:0] low_oh;
  logic [N_CORE-1:0] out_d;
  logic              unused_data;

  assign unused_data = ^data;

  assign active = en && !mask_q && irq_in && (|dest_q);
  assign rel    = own_v_q && done[own_q];
  assign keep   = own_v_q && !rel && dest_q[own_q];
  assign base   = rel ? own_q : last_q;
  assign low_oh = dest_q & (~dest_q + N_CORE'(1));

  // rotating search: first set mask bit strictly after base, wrapping
  always_comb begin
    int t;
    logic found;
    nxt   = base;
    found = 1'b0;
    for (int k = 1; k <= N_CORE; k++) begin
      t = (int'(base) + k) % N_CORE;
      if (!found && dest_q[t]) begin
        nxt   = CORE_W'(t);
        found = 1'b1;
      end
    end
  end

  assign sel = keep ? own_q : nxt;

  always_comb begin
    out_d = '0;
    if (active) begin
      case (dist_q)
        DIST_RR:  out_d[sel] = 1'b1;
        DIST_ALL: out_d = dest_q;
        default:  out_d = low_oh;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dest_q  <= '0;
      dist_q  <= DIST_RR;
      mask_q  <= 1'b1;
      own_q   <= '0;
      own_v_q <= 1'b0;
      last_q  <= CORE_W'(N_CORE - 1);
      out_q   <= '0;
    end else begin
      if (wr_dest) dest_q <= data[N_CORE-1:0];
      if (wr_mode) dist_q <= cidu_dist_e'(data[1:0]);
      if (wr_mask) mask_q <= data[0];
      if (rel) last_q <= own_q;
      if (active && dist_q == DIST_RR) begin
        own_q   <= sel;
        own_v_q <= 1'b1;
      end else begin
        own_v_q <= 1'b0;
      end
      out_q <= out_d;
    end
  end

  // R9: nothing outside the core mask is ever driven
  p_inside_mask_r9: assert property (@(posedge clk) disable iff (rst)
    (out_q & ~$past(dest_q)) == '0);

  // R3: a masked interrupt stays quiet
  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    $past(mask_q) |-> out_q == '0);

  // R7: load-balanced delivery serves at most one core
  p_rr_single_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(dist_q) == DIST_RR) |-> $onehot0(out_q));

  // R4: fixed delivery serves at most one core
  p_fixed_single_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(dist_q) == DIST_ONE || $past(dist_q) == DIST_ONE_ALT) |-> $onehot0(out_q));

  // R7: an owner without completion keeps the request
  p_rr_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (own_v_q && !done[own_q] && dest_q[own_q] && active && dist_q == DIST_RR)
      |=> out_q == $past(out_q));

endmodule

// File: rtl/cidu_top.sv
module cidu_top
  import cidu_pkg::*;
#(
  parameter int N_IRQ  = 4,
  parameter int N_CORE = 4,
  parameter int DATA_W = 8,
  localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic [IDX_W-1:0]         cmd_idx,
  input  logic [DATA_W-1:0]        cmd_data,
  input  logic [N_IRQ-1:0]         irq_in,
  input  logic [N_CORE-1:0]        core_done,
  output logic [N_IRQ*N_CORE-1:0]  irq_out
);

  logic [N_IRQ-1:0] wr_dest;
  logic [N_IRQ-1:0] wr_mode;
  logic [N_IRQ-1:0] wr_mask;
  logic             en_q;

  cidu_cmd_dec #(.N_IRQ(N_IRQ)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_idx   (cmd_idx),
    .wr_dest   (wr_dest),
    .wr_mode   (wr_mode),
    .wr_mask   (wr_mask),
    .en_q      (en_q)
  );

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    cidu_route #(.N_CORE(N_CORE), .DATA_W(DATA_W)) u_route (
      .clk     (clk),
      .rst     (rst),
      .en      (en_q),
      .irq_in  (irq_in[i]),
      .done    (core_done),
      .wr_dest (wr_dest[i]),
      .wr_mode (wr_mode[i]),
      .wr_mask (wr_mask[i]),
      .data    (cmd_data),
      .out_q   (irq_out[i*N_CORE +: N_CORE])
    );
  end

  // R2: a disabled unit drives nothing
  p_off_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(en_q) |-> irq_out == '0);

endmodule

// File: tb/tb_cidu_top.sv
`timescale 1ns/100ps
module tb_cidu_top;
  localparam int N_IRQ  = 4;
  localparam int N_CORE = 4;
  localparam int W      = N_IRQ * N_CORE;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic [1:0]   cmd_op = '0;
  logic [1:0]   cmd_idx = '0;
  logic [7:0]   cmd_data = '0;
  logic [3:0]   irq_in = '0;
  logic [3:0]   core_done = '0;
  logic [W-1:0] irq_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #2.5 clk = ~clk;

  cidu_top dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_data(cmd_data), .irq_in(irq_in),
    .core_done(core_done), .irq_out(irq_out)
  );

  // monitor: compares one expected item per clock, 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (irq_out !== e) begin
          n_fail++;
          $display("FAIL %s: irq_out=%h expected %h", t, irq_out, e);
        end
      end
    end
  end

  task automatic cmd(input logic [1:0] op, input logic [1:0] idx, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // driver: apply inputs at a falling edge, push the expected output
  task automatic step(input logic [3:0] in, input logic [3:0] dn,
                      input logic [W-1:0] e, input string tag);
    @(negedge clk);
    irq_in = in; core_done = dn;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    core_done = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: irq_out=%h expected completion", irq_out);
    finish_run();
  end

  initial begin
    irq_in = 4'hF;
    repeat (4) @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (irq_out !== '0) begin
      n_fail++;
      $display("FAIL R1: irq_out=%h expected %h", irq_out, {W{1'b0}});
    end
    rst = 1'b0;
    step(4'hF, 4'h0, 16'h0000, "R1 all masked after reset");

    // irq0: fixed delivery to mask 0110 -> core 1
    cmd(2'd0, 2'd0, 8'h06);
    cmd(2'd1, 2'd0, 8'h11);
    cmd(2'd2, 2'd0, 8'h00);
    step(4'h1, 4'h0, 16'h0000, "R2 not enabled");
    cmd(2'd3, 2'd2, 8'h00);
    step(4'h1, 4'h0, 16'h0002, "R4 lowest mask bit");
    step(4'h0, 4'h0, 16'h0000, "R10 input low");
    step(4'h1, 4'h0, 16'h0002, "R10 one-cycle latency");
    cmd(2'd2, 2'd0, 8'h01);
    step(4'h1, 4'h0, 16'h0000, "R3 masked");
    cmd(2'd2, 2'd0, 8'h00);
    step(4'h1, 4'h0, 16'h0002, "R3 unmasked");
    cmd(2'd1, 2'd0, 8'hEF);
    step(4'h1, 4'h0, 16'h0002, "R5 field 3 with junk bits");
    cmd(2'd1, 2'd0, 8'h01);
    step(4'h1, 4'h0, 16'h0002, "R5 trigger bit clear");

    // irq2: broadcast, empty mask first
    cmd(2'd1, 2'd2, 8'h12);
    cmd(2'd2, 2'd2, 8'h00);
    step(4'h4, 4'h0, 16'h0000, "R9 empty mask");
    cmd(2'd0, 2'd2, 8'h0D);
    step(4'h4, 4'h0, 16'h0D00, "R6 broadcast");

    // irq3: fixed delivery, mask 1100 -> core 2
    cmd(2'd0, 2'd3, 8'h0C);
    cmd(2'd1, 2'd3, 8'h11);
    cmd(2'd2, 2'd3, 8'h00);
    step(4'h8, 4'h0, 16'h4000, "R4 mask 1100");

    // irq1: load-balanced over cores 0,1,3
    step(4'h0, 4'h0, 16'h0000, "R9 idle");
    cmd(2'd0, 2'd1, 8'h0B);
    cmd(2'd1, 2'd1, 8'h10);
    cmd(2'd2, 2'd1, 8'h00);
    step(4'h2, 4'h0, 16'h0010, "R8 first owner lowest bit");
    step(4'h2, 4'h4, 16'h0010, "R7 non-owner completion ignored");
    step(4'h2, 4'h1, 16'h0020, "R8 next after core 0");
    step(4'h2, 4'h0, 16'h0020, "R7 owner held");
    step(4'h2, 4'h2, 16'h0080, "R8 skip core 2");
    step(4'h2, 4'h8, 16'h0010, "R8 wrap to core 0");
    step(4'h0, 4'h0, 16'h0000, "R7 input low");
    step(4'h3, 4'h0, 16'h0012, "R7 with fixed irq0");
    step(4'hF, 4'h0, 16'h4D12, "R6 all schemes together");

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule